// File: doc/BRIEF.md
# Latched Event Register Bank with Interrupt Combine

This block holds one 8-bit sticky event register for each port of a multi-port line interface. Each port has eight live status inputs from its line circuits, such as jitter buffer level, driver monitor, pattern checker and receiver alarms. The block watches them and latches a bit whenever that input's own trigger condition occurs. Depending on the bit, the trigger is either edge of the status, only its rising edge, or an error pulse that counts only while the pattern checker reports lock.

Software reaches the bank through a simple synchronous bus. It reads the latched bits without side effects and acknowledges chosen bits by writing ones to them. Each port also has a plain read/write enable register of the same width. A port's interrupt output is high while any latched bit has its enable bit set. Ports are placed at a fixed address stride, with the latched register and the enable register at fixed offsets inside each window.

Top module: `evtlat_bank`

## Requirements
- R1: Bit positions in each latched and enable register are: 7 jitter buffer full, 6 jitter buffer empty, 5 transmit driver monitor, 4 pattern checker output, 3 pattern bit error, 2 receive code violation, 1 receive clock-lock loss, 0 receive signal loss. After reset, every latched bit, every enable bit and every interrupt output is 0.
- R2: Port p (0 to NUM_PORTS-1) has its latched register at address p*16+4 and its enable register at p*16+5. Reads of any other address return 0, and writes to it change no register.
- R3: Writing a 1 to a latched bit clears it. A 0 in the written data leaves that bit unchanged. A read changes nothing.
- R4: Bits 5, 4, 1 and 0 set when their live input differs from its value in the previous cycle, for both rising and falling changes.
- R5: Bit 2 sets only when its live input is 1 and was 0 in the previous cycle. A falling change does not set it.
- R6: Bits 7 and 6 set when their condition goes from 0 to 1. After a clear, a condition that stays at 1 does not set them again. It sets them only after it has gone to 0 and returned to 1.
- R7: Bit 3 sets in every cycle in which its error input is 1 while the port's lock input is 1. When lock is 0, the error input has no effect.
- R8: Each port's interrupt output is the OR over the eight bits of latched AND enable. It falls when the last such bit is cleared or its enable is written to 0.
- R9: When a trigger and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R10: The enable register reads back the last value written to it.
- R11: A trigger on the inputs before clock edge k is visible on the read data and the interrupt output right after edge k. The previous-value sample of each input is 0 when leaving reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock; all inputs are synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| stat_live | input | NUM_PORTS*8 | Live status inputs; byte p belongs to port p, bit layout as in R1 |
| chk_lock | input | NUM_PORTS | Pattern checker lock indication, one per port |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational from register state |
| irq | output | NUM_PORTS | Per-port active-high interrupt |

## Verification
The bench builds the block with its default parameters: four ports, a 16-byte stride and a 6-bit address. With these values the random address stream covers every mapped and unmapped location, so cross-port write isolation and unmapped-offset behaviour are both exercised. Random input toggling at a low rate, combined with random clears and enable writes, regularly produces the case where a set and a clear land in the same cycle. Directed sequences cover a buffer condition held high across a clear, falling edges on the rise-only bit, and error pulses with lock dropped.

// File: rtl/evtlat_pkg.sv
// Package: shared constants and trigger kinds for the latched event bank.
// Assumes an 8-bit register layout fixed by the bit positions below.
package evtlat_pkg;

    localparam int EV_W = 8;

    // Bit positions; the trigger kind of each bit depends on its position.
    localparam int B_BUF_FULL  = 7;
    localparam int B_BUF_EMPTY = 6;
    localparam int B_DRV_MON   = 5;
    localparam int B_CHK_OUT   = 4;
    localparam int B_CHK_ERR   = 3;
    localparam int B_CODE_VIOL = 2;
    localparam int B_CLK_LOSS  = 1;
    localparam int B_SIG_LOSS  = 0;

    typedef enum logic [1:0] {
        TRG_EDGE  = 2'd0,
        TRG_RISE  = 2'd1,
        TRG_GATED = 2'd2
    } trig_e;

    // Maps a bit position to the trigger kind it uses.
    function automatic trig_e trig_of(input int b);
        case (b)
            B_BUF_FULL, B_BUF_EMPTY, B_CODE_VIOL: trig_of = TRG_RISE;
            B_CHK_ERR:                            trig_of = TRG_GATED;
            default:                              trig_of = TRG_EDGE;
        endcase
    endfunction

endpackage

// File: rtl/evtlat_trig.sv
// Module: evtlat_trig
// Turns one live status input into a one-cycle set request for its latched bit.
// KIND picks either-edge, rising-edge or gated-level detection.
// Assumes live_i is synchronous to clk; the previous sample resets to 0.
module evtlat_trig
    import evtlat_pkg::*;
#(
    parameter trig_e KIND = TRG_EDGE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic live_i,
    input  logic gate_i,
    output logic evt_o
);

    generate
        if (KIND == TRG_GATED) begin : g_gated
            // Error pulses count only while the gate is high; no history kept.
            assign evt_o = live_i & gate_i;
        end else begin : g_hist
            logic prev_q;
            logic unused_gate;
            assign unused_gate = gate_i;

            // Keep the previous cycle's sample for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= live_i;
            end

            if (KIND == TRG_RISE) begin : g_rise
                // Request only on a 0-to-1 change.
                assign evt_o = live_i & ~prev_q;
            end else begin : g_edge
                // Request on any change of the input.
                assign evt_o = live_i ^ prev_q;
            end
        end
    endgenerate

endmodule

// File: rtl/evtlat_port.sv
// Module: evtlat_port
// One port's latched event register, enable register and interrupt combine.
// Set requests beat a write-one-to-clear on the same bit in the same cycle.
// Assumes the write strobes come from an already decoded bus.
module evtlat_port
    import evtlat_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] live_i,
    input  logic            lock_i,
    input  logic            wr_lat_i,
    input  logic            wr_ena_i,
    input  logic [EV_W-1:0] wdata_i,
    output logic [EV_W-1:0] lat_o,
    output logic [EV_W-1:0] ena_o,
    output logic            irq_o
);

    logic [EV_W-1:0] evt;
    logic [EV_W-1:0] clr;
    logic [EV_W-1:0] lat_q;
    logic [EV_W-1:0] ena_q;

    // One trigger detector per bit, kind chosen by bit position.
    generate
        for (genvar b = 0; b < EV_W; b++) begin : g_bit
            evtlat_trig #(
                .KIND (trig_of(b))
            ) u_trig (
                .clk    (clk),
                .rst_n  (rst_n),
                .live_i (live_i[b]),
                .gate_i ((b == B_CHK_ERR) ? lock_i : 1'b0),
                .evt_o  (evt[b])
            );
        end
    endgenerate

    // Bits the host asks to clear this cycle.
    always_comb begin
        clr = wr_lat_i ? wdata_i : '0;
    end

    // Sticky event bits: clear on write-one, then set by any request.
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= (lat_q & ~clr) | evt;
    end

    // Plain read/write enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)        ena_q <= '0;
        else if (wr_ena_i) ena_q <= wdata_i;
    end

    // Interrupt combine over enabled latched bits.
    always_comb begin
        irq_o = |(lat_q & ena_q);
    end

    assign lat_o = lat_q;
    assign ena_o = ena_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((lat_q & $past(evt)) == $past(evt))); // R9
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lat_i |=> ((lat_q & $past(wdata_i & ~evt)) == '0)); // R3
    AST_NO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lat_i |=> ((lat_q & $past(lat_q)) == $past(lat_q))); // R3
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_q == '0) |-> !irq_o); // R8
    AST_ERR_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_q[B_CHK_ERR]) |-> $past(lock_i)); // R7
    AST_CV_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_q[B_CODE_VIOL]) |-> $past(live_i[B_CODE_VIOL])); // R5
    AST_ENA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ena_i |=> $stable(ena_q)); // R10

endmodule

// File: rtl/evtlat_bank.sv
// Module: evtlat_bank
// Top of the latched event bank: address decode, per-port instances and read mux.
// Port p occupies a window of PORT_STRIDE bytes starting at p*PORT_STRIDE.
// Assumes PORT_STRIDE is a power of two and the windows fit in ADDR_W bits.
module evtlat_bank
    import evtlat_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int ADDR_W      = 6,
    parameter int PORT_STRIDE = 16,
    parameter int LAT_OFS     = 4,
    parameter int ENA_OFS     = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PORTS*EV_W-1:0] stat_live,
    input  logic [NUM_PORTS-1:0]      chk_lock,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic [EV_W-1:0]           bus_wdata,
    output logic [EV_W-1:0]           bus_rdata,
    output logic [NUM_PORTS-1:0]      irq
);

    localparam int OFS_W = $clog2(PORT_STRIDE);
    localparam int SEL_W = ADDR_W - OFS_W;

    logic [OFS_W-1:0]     ofs;
    logic [SEL_W-1:0]     sel;
    logic                 is_lat;
    logic                 is_ena;
    logic [NUM_PORTS-1:0] hit;
    logic [NUM_PORTS-1:0] wr_lat;
    logic [NUM_PORTS-1:0] wr_ena;
    logic [EV_W-1:0]      lat_a [NUM_PORTS];
    logic [EV_W-1:0]      ena_a [NUM_PORTS];

    // Split the address into window select and offset inside the window.
    always_comb begin
        ofs    = bus_addr[OFS_W-1:0];
        sel    = bus_addr[ADDR_W-1:OFS_W];
        is_lat = (ofs == OFS_W'(LAT_OFS));
        is_ena = (ofs == OFS_W'(ENA_OFS));
    end

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            // Window match and write strobes for this port.
            assign hit[p]    = (sel == SEL_W'(p));
            assign wr_lat[p] = bus_wr & hit[p] & is_lat;
            assign wr_ena[p] = bus_wr & hit[p] & is_ena;

            evtlat_port u_port (
                .clk      (clk),
                .rst_n    (rst_n),
                .live_i   (stat_live[p*EV_W +: EV_W]),
                .lock_i   (chk_lock[p]),
                .wr_lat_i (wr_lat[p]),
                .wr_ena_i (wr_ena[p]),
                .wdata_i  (bus_wdata),
                .lat_o    (lat_a[p]),
                .ena_o    (ena_a[p]),
                .irq_o    (irq[p])
            );
        end
    endgenerate

    // Read mux: selected register of the addressed port, 0 elsewhere.
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (hit[p] && is_lat) bus_rdata = lat_a[p];
            if (hit[p] && is_ena) bus_rdata = ena_a[p];
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_lat, wr_ena})); // R2
    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |-> ((wr_lat == '0) && (wr_ena == '0))); // R2

endmodule

// File: tb/evtlat_bank_tb.sv
module evtlat_bank_tb;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP*8-1:0] stat_live = '0;
    logic [NP-1:0] chk_lock = '0;
    logic [5:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [NP-1:0] irq;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_prev [NP];
    logic [7:0] m_lat  [NP];
    logic [7:0] m_ena  [NP];

    always #4 clk = ~clk;

    evtlat_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_live (stat_live),
        .chk_lock  (chk_lock),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Expected set requests for one port from the trigger rules.
    function automatic logic [7:0] f_evt(input logic [7:0] live, input logic [7:0] prev,
                                         input logic lock);
        logic [7:0] e;
        e = ((live ^ prev) & 8'b0011_0011) | (live & ~prev & 8'b1100_0100);
        e[3] = live[3] & lock;
        return e;
    endfunction

    // Expected read data for an address.
    function automatic logic [7:0] f_read(input logic [5:0] a);
        if (a[3:0] == 4'd4) return m_lat[a[5:4]];
        if (a[3:0] == 4'd5) return m_ena[a[5:4]];
        return 8'h00;
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // One clock: drive inputs, update the model, check outputs after the edge.
    task automatic step(input logic [NP*8-1:0] live, input logic [NP-1:0] lock,
                        input logic wr, input logic [5:0] a, input logic [7:0] wd,
                        input string tag);
        @(negedge clk);
        stat_live = live; chk_lock = lock; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        for (int p = 0; p < NP; p++) begin
            logic [7:0] clr;
            logic [7:0] ev;
            clr = (wr && a[5:4] == p[1:0] && a[3:0] == 4'd4) ? wd : 8'h00;
            ev  = f_evt(live[p*8 +: 8], m_prev[p], lock[p]);
            m_lat[p]  = (m_lat[p] & ~clr) | ev;
            if (wr && a[5:4] == p[1:0] && a[3:0] == 4'd5) m_ena[p] = wd;
            m_prev[p] = live[p*8 +: 8];
        end
        @(posedge clk);
        #2;
        for (int p = 0; p < NP; p++) begin
            check8({tag, " R8 irq"}, {7'd0, irq[p]}, {7'd0, |(m_lat[p] & m_ena[p])});
        end
        check8({tag, " rdata"}, bus_rdata, f_read(a));
    endtask

    logic [NP*8-1:0] cur;

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog R11 actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int p = 0; p < NP; p++) begin
            m_prev[p] = '0; m_lat[p] = '0; m_ena[p] = '0;
        end
        cur = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register and interrupt.
        for (int p = 0; p < NP; p++) begin
            step(cur, '0, 1'b0, 6'(p * 16 + 4), 8'h00, "R1 lat reset");
            step(cur, '0, 1'b0, 6'(p * 16 + 5), 8'h00, "R1 ena reset");
        end

        // R10: enable read/write per port.
        for (int p = 0; p < NP; p++)
            step(cur, '0, 1'b1, 6'(p * 16 + 5), 8'hFF, "R10 ena write");
        step(cur, '0, 1'b0, 6'd21, 8'h00, "R10 ena readback");

        // R4: falling change on an either-edge bit sets it.
        cur[0] = 1'b1; step(cur, '0, 1'b0, 6'd4, 8'h00, "R4 rise bit0");
        step(cur, '0, 1'b1, 6'd4, 8'h01, "R3 clear bit0");
        cur[0] = 1'b0; step(cur, '0, 1'b0, 6'd4, 8'h00, "R4 fall bit0");

        // R5: falling change on the code violation bit does not set it.
        cur[2] = 1'b1; step(cur, '0, 1'b1, 6'd4, 8'hFF, "R5 rise+clear");
        step(cur, '0, 1'b1, 6'd4, 8'hFF, "R5 clear");
        cur[2] = 1'b0; step(cur, '0, 1'b0, 6'd4, 8'h00, "R5 fall ignored");

        // R6: buffer full held high does not re-set after a clear.
        cur[7] = 1'b1; step(cur, '0, 1'b0, 6'd4, 8'h00, "R6 full set");
        step(cur, '0, 1'b1, 6'd4, 8'h80, "R6 clear");
        repeat (4) step(cur, '0, 1'b0, 6'd4, 8'h00, "R6 persist no reset");
        cur[7] = 1'b0; step(cur, '0, 1'b0, 6'd4, 8'h00, "R6 drop");
        cur[7] = 1'b1; step(cur, '0, 1'b0, 6'd4, 8'h00, "R6 return sets");

        // R7: error pulse without lock has no effect, with lock it sets.
        step(cur, '0, 1'b1, 6'd4, 8'hFF, "R7 clear all");
        cur[3] = 1'b1; step(cur, 4'b0000, 1'b0, 6'd4, 8'h00, "R7 no lock");
        step(cur, 4'b0001, 1'b0, 6'd4, 8'h00, "R7 with lock");
        cur[3] = 1'b0;

        // R9: set and clear on the same bit in the same cycle.
        step(cur, '0, 1'b1, 6'd4, 8'hFF, "R9 prep clear");
        cur[1] = 1'b1; step(cur, '0, 1'b1, 6'd4, 8'h02, "R9 set wins");

        // R2: unmapped offset write changes nothing and reads 0.
        cur[15:8] = 8'h21; step(cur, '0, 1'b0, 6'd20, 8'h00, "R2 port1 set");
        step(cur, '0, 1'b1, 6'd16, 8'hFF, "R2 unmapped write");
        step(cur, '0, 1'b0, 6'd20, 8'h00, "R2 port1 intact");

        // R8: disabling the enable drops the interrupt.
        step(cur, '0, 1'b1, 6'd21, 8'h00, "R8 ena off");

        // R11 / R3 / R4: random traffic checked against the model.
        for (int i = 0; i < 4000; i++) begin
            logic [NP*8-1:0] flip;
            logic [5:0] a;
            logic [3:0] o;
            flip = $urandom & $urandom & $urandom;
            cur  = cur ^ flip;
            case ($urandom_range(0, 3))
                0:       o = 4'($urandom_range(0, 15));
                1, 2:    o = 4'd4;
                default: o = 4'd5;
            endcase
            a = {2'($urandom_range(0, 3)), o};
            step(cur, 4'($urandom | $urandom), ($urandom_range(0, 3) == 0), a,
                 8'($urandom), "R11 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule